// File: doc/BRIEF.md
# Effective Address and Operand Fetch Unit

This unit sits between instruction decode and the accumulator datapath. For each instruction it receives a four-bit addressing-mode code, the instruction's address field, the program counter value after the whole instruction has been fetched, and a register number. It forms the effective address (EA) under the chosen mode and performs the memory reads needed to return the operand. It reports the EA, the operand and a single-cycle completion pulse.

Eight general registers and one index register are held inside. Auto-increment and auto-decrement modes write the stepped pointer back into the selected register. The base-register mode uses the selected general register as its base. Indexed mode uses the index register. Both share one adder path with the field.

A side port loads the registers between instructions. Memory is a single synchronous read port. The address is held with a level request until a one-cycle read-valid strobe returns the data.

Top module: `ea_fetch_unit`

Mode codes on `mode`: 0 implied, 1 immediate, 2 direct, 3 indirect, 4 register, 5 register indirect, 6 auto-increment, 7 auto-decrement, 8 relative, 9 indexed, 10 base register. Codes 11 to 15 are reserved and behave like implied. All address arithmetic wraps modulo 2^16. The 12-bit field is zero-extended, except in relative mode, where it is sign-extended (bit 11 is the sign).

## Requirements
- R1: After reset, `done` and `mem_req` are low, `ea` and `operand` are 0, and every register reads as 0.
- R2: Direct mode gives EA equal to the zero-extended field and the operand M[EA], using exactly one memory read.
- R3: Indirect mode first reads M[field], uses that word as the EA, then reads the operand from M[EA], for exactly two reads; the first read's address is the field.
- R4: Relative mode gives EA = PC + sign-extended field, wrapped to 16 bits (PC 202 with field 500 gives 702; PC 751 with field 0xFCB gives 698).
- R5: Indexed mode gives EA = index register + field, and base-register mode gives EA = selected register + field, each with one read.
- R6: Register-indirect mode uses the selected register as EA and leaves that register unchanged.
- R7: Auto-increment mode uses the selected register as EA and then leaves the register one higher, written exactly once.
- R8: Auto-decrement mode lowers the selected register by one first and uses the lowered value as the EA.
- R9: Immediate mode returns the zero-extended field, and register mode returns the selected register. Both issue no memory read, report EA 0, and raise `done` in the cycle right after the start edge.
- R10: Implied mode and reserved codes 11 to 15 issue no read and raise `done` one cycle after start, with EA and operand both 0.
- R11: A `start` that arrives while an instruction is in progress is ignored. It causes no register update and no extra `done`.
- R12: `mem_addr` stays stable while `mem_req` is high and no read-valid has come. `done` is a single-cycle pulse that follows the final read by one cycle.
- R13: A register load from the side port is honoured only while the unit is idle; one that arrives during an instruction is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one operand fetch |
| mode | input | 4 | Addressing-mode code |
| addr_field | input | 12 | Instruction address field |
| pc_upd | input | 16 | Program counter after full instruction fetch |
| reg_sel | input | 3 | Selected general register |
| rf_wr_en | input | 1 | Side-port load of a general register |
| rf_wr_idx | input | 3 | Register number for side-port load |
| rf_wr_data | input | 16 | Side-port load value |
| xr_wr_en | input | 1 | Side-port load of the index register |
| xr_wr_data | input | 16 | Index register load value |
| mem_req | output | 1 | Read request, held until read-valid |
| mem_addr | output | 16 | Read address |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 16 | Read data |
| ea | output | 16 | Effective address of the last instruction |
| operand | output | 16 | Operand of the last instruction |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two kinds of fault can stay hidden for a while. A stale or miscomputed pointer write-back does not appear on `ea` or `operand` of the instruction that caused it. It shows only when a later register-mode or register-indirect instruction reads that register, so the bench re-reads registers after each stepping instruction. A sequencer fault shows sooner. A wrong state shows as a read count other than zero, one or two, a first indirect read at the wrong address, or a `done` pulse that is late, doubled or missing, all within a few cycles of the start.

// File: rtl/ea_pkg.sv
package ea_pkg;

   localparam logic [3:0] MD_IMPL = 4'd0;
   localparam logic [3:0] MD_IMM  = 4'd1;
   localparam logic [3:0] MD_DIR  = 4'd2;
   localparam logic [3:0] MD_IND  = 4'd3;
   localparam logic [3:0] MD_REG  = 4'd4;
   localparam logic [3:0] MD_RIND = 4'd5;
   localparam logic [3:0] MD_AINC = 4'd6;
   localparam logic [3:0] MD_ADEC = 4'd7;
   localparam logic [3:0] MD_REL  = 4'd8;
   localparam logic [3:0] MD_IDX  = 4'd9;
   localparam logic [3:0] MD_BASE = 4'd10;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_CALC   = 3'd1,
      S_IND_RD = 3'd2,
      S_OP_RD  = 3'd3,
      S_DONE   = 3'd4
   } fetch_state_e;

   // Modes that need at least one memory read for the operand
   function automatic logic needs_mem(input logic [3:0] m);
      return (m == MD_DIR) || (m == MD_IND) ||
             ((m >= MD_RIND) && (m <= MD_BASE));
   endfunction

endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
   parameter int WORD_W = 16,
   parameter int NREGS  = 8,
   localparam int SEL_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  widx,
   input  logic [WORD_W-1:0] wdata,
   input  logic              xr_we,
   input  logic [WORD_W-1:0] xr_wdata,
   input  logic [SEL_W-1:0]  ridx,
   output logic [WORD_W-1:0] rdata,
   output logic [WORD_W-1:0] xr
);

   logic [WORD_W-1:0] regs [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (we && (int'(widx) == g))
            regs[g] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         xr <= '0;
      else if (xr_we)
         xr <= xr_wdata;
   end

   assign rdata = (int'(ridx) < NREGS) ? regs[ridx] : '0;

endmodule

// File: rtl/ea_calc.sv
module ea_calc
   import ea_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int FIELD_W    = 12,
   parameter bit REL_SIGNED = 1'b1
) (
   input  logic [3:0]         mode,
   input  logic [FIELD_W-1:0] field,
   input  logic [WORD_W-1:0]  pc,
   input  logic [WORD_W-1:0]  rval,
   input  logic [WORD_W-1:0]  xr,
   output logic [WORD_W-1:0]  ea
);

   logic [WORD_W-1:0] field_z;
   logic [WORD_W-1:0] rel_off;
   logic [WORD_W-1:0] add_base;

   assign field_z = WORD_W'(field);

   if (REL_SIGNED) begin : g_rel_sext
      assign rel_off = WORD_W'(signed'(field));
   end else begin : g_rel_zext
      assign rel_off = field_z;
   end

   // One shared adder: the base is PC, the index register or a general register
   always_comb begin
      unique case (mode)
         MD_REL:  add_base = pc;
         MD_IDX:  add_base = xr;
         default: add_base = rval;
      endcase
   end

   always_comb begin
      unique case (mode)
         MD_DIR, MD_IND:           ea = field_z;
         MD_RIND, MD_AINC:         ea = rval;
         MD_ADEC:                  ea = rval - WORD_W'(1);
         MD_REL:                   ea = add_base + rel_off;
         MD_IDX, MD_BASE:          ea = add_base + field_z;
         default:                  ea = '0;
      endcase
   end

endmodule

// File: rtl/ea_fetch_unit.sv
module ea_fetch_unit
   import ea_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int FIELD_W    = 12,
   parameter int NREGS      = 8,
   parameter bit REL_SIGNED = 1'b1,
   localparam int SEL_W     = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [3:0]         mode,
   input  logic [FIELD_W-1:0] addr_field,
   input  logic [WORD_W-1:0]  pc_upd,
   input  logic [SEL_W-1:0]   reg_sel,
   input  logic               rf_wr_en,
   input  logic [SEL_W-1:0]   rf_wr_idx,
   input  logic [WORD_W-1:0]  rf_wr_data,
   input  logic               xr_wr_en,
   input  logic [WORD_W-1:0]  xr_wr_data,
   output logic               mem_req,
   output logic [WORD_W-1:0]  mem_addr,
   input  logic               mem_rvalid,
   input  logic [WORD_W-1:0]  mem_rdata,
   output logic [WORD_W-1:0]  ea,
   output logic [WORD_W-1:0]  operand,
   output logic               done
);

   if (FIELD_W < 2 || FIELD_W > WORD_W) begin : g_bad_field
      $error("ea_fetch_unit: FIELD_W must lie in 2..WORD_W");
   end
   if (NREGS < 1) begin : g_bad_nregs
      $error("ea_fetch_unit: NREGS must be at least 1");
   end

   fetch_state_e       st_q;
   logic [3:0]         mode_q;
   logic [FIELD_W-1:0] field_q;
   logic [WORD_W-1:0]  pc_q;
   logic [SEL_W-1:0]   sel_q;
   logic [WORD_W-1:0]  ea_q;
   logic [WORD_W-1:0]  opnd_q;

   logic               idle;
   logic [SEL_W-1:0]   rd_idx;
   logic [WORD_W-1:0]  r_val;
   logic [WORD_W-1:0]  xr_val;
   logic [WORD_W-1:0]  calc_ea;
   logic               wb_dec, wb_inc;
   logic               rf_we;
   logic [SEL_W-1:0]   rf_widx;
   logic [WORD_W-1:0]  rf_wdata;

   assign idle   = (st_q == S_IDLE);
   assign rd_idx = idle ? reg_sel : sel_q;

   // Pointer write-back: decrement before the read, increment with the final read
   assign wb_dec = (st_q == S_CALC)  && (mode_q == MD_ADEC);
   assign wb_inc = (st_q == S_OP_RD) && mem_rvalid && (mode_q == MD_AINC);

   assign rf_we    = wb_dec || wb_inc || (idle && rf_wr_en);
   assign rf_widx  = (wb_dec || wb_inc) ? sel_q : rf_wr_idx;
   assign rf_wdata = wb_dec ? calc_ea :
                     wb_inc ? (ea_q + WORD_W'(1)) : rf_wr_data;

   ea_regfile #(
      .WORD_W (WORD_W),
      .NREGS  (NREGS)
   ) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (rf_we),
      .widx     (rf_widx),
      .wdata    (rf_wdata),
      .xr_we    (idle && xr_wr_en),
      .xr_wdata (xr_wr_data),
      .ridx     (rd_idx),
      .rdata    (r_val),
      .xr       (xr_val)
   );

   ea_calc #(
      .WORD_W     (WORD_W),
      .FIELD_W    (FIELD_W),
      .REL_SIGNED (REL_SIGNED)
   ) u_calc (
      .mode  (mode_q),
      .field (field_q),
      .pc    (pc_q),
      .rval  (r_val),
      .xr    (xr_val),
      .ea    (calc_ea)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         mode_q  <= MD_IMPL;
         field_q <= '0;
         pc_q    <= '0;
         sel_q   <= '0;
         ea_q    <= '0;
         opnd_q  <= '0;
      end else begin
         unique case (st_q)
            S_IDLE: if (start) begin
               mode_q  <= mode;
               field_q <= addr_field;
               pc_q    <= pc_upd;
               sel_q   <= reg_sel;
               if (needs_mem(mode)) begin
                  st_q <= S_CALC;
               end else begin
                  st_q   <= S_DONE;
                  ea_q   <= '0;
                  opnd_q <= (mode == MD_IMM) ? WORD_W'(addr_field) :
                            (mode == MD_REG) ? r_val : '0;
               end
            end
            S_CALC: begin
               ea_q <= calc_ea;
               st_q <= (mode_q == MD_IND) ? S_IND_RD : S_OP_RD;
            end
            S_IND_RD: if (mem_rvalid) begin
               ea_q <= mem_rdata;
               st_q <= S_OP_RD;
            end
            S_OP_RD: if (mem_rvalid) begin
               opnd_q <= mem_rdata;
               st_q   <= S_DONE;
            end
            S_DONE:  st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign mem_req  = (st_q == S_IND_RD) || (st_q == S_OP_RD);
   assign mem_addr = (st_q == S_IND_RD) ? WORD_W'(field_q) : ea_q;
   assign ea       = ea_q;
   assign operand  = opnd_q;
   assign done     = (st_q == S_DONE);

endmodule

// File: rtl/ea_fetch_unit_chk.sv
module ea_fetch_unit_chk
   import ea_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [3:0]        mode,
   input logic              mem_req,
   input logic [WORD_W-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              done,
   input fetch_state_e      st,
   input logic [3:0]        mode_q
);

   // R12: the read address is held until the data strobe arrives
   a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   // R12: completion is a single-cycle pulse
   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12: the final read strobe is followed by done
   a_r12_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_OP_RD && mem_rvalid) |=> (done && !mem_req));

   // R9 / R10: no-memory modes finish one cycle after start without a read
   a_r9_fast_done: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && start && !needs_mem(mode)) |=> (done && !mem_req));

   // R11: the latched mode does not change while an instruction is in flight
   a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE) |=> $stable(mode_q));

   // R3: an indirect pointer read is always followed by an operand read
   a_r3_second_read: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IND_RD && mem_rvalid) |=> (mem_req && !done));

endmodule

bind ea_fetch_unit ea_fetch_unit_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .mode       (mode),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid),
   .done       (done),
   .st         (st_q),
   .mode_q     (mode_q)
);

// File: tb/ea_fetch_unit_test.sv
module ea_fetch_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic [11:0] addr_field = '0;
   logic [15:0] pc_upd = '0;
   logic [2:0]  reg_sel = '0;
   logic        rf_wr_en = 1'b0;
   logic [2:0]  rf_wr_idx = '0;
   logic [15:0] rf_wr_data = '0;
   logic        xr_wr_en = 1'b0;
   logic [15:0] xr_wr_data = '0;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic [15:0] ea, operand;
   logic        done;

   int n_chk = 0, n_bad = 0;
   int rd_cnt = 0;
   logic [15:0] rd_first = '0;
   int unsigned lat = 0;
   logic [15:0] mr [8];
   logic [15:0] mxr = '0;

   always #5 clk = ~clk;

   ea_fetch_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .addr_field(addr_field), .pc_upd(pc_upd), .reg_sel(reg_sel),
      .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
      .xr_wr_en(xr_wr_en), .xr_wr_data(xr_wr_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .ea(ea), .operand(operand), .done(done)
   );

   function automatic logic [15:0] mval(input logic [15:0] a);
      case (a)
         16'd399: return 16'd450;
         16'd400: return 16'd700;
         16'd500: return 16'd800;
         16'd600: return 16'd900;
         16'd702: return 16'd325;
         16'd800: return 16'd300;
         default: return (a ^ 16'hA5C3) + 16'd17;
      endcase
   endfunction

   // Memory model: random 0..2 cycle latency, one-cycle valid strobe
   always @(negedge clk) begin
      if (mem_rvalid) begin
         mem_rvalid = 1'b0;
         lat = $urandom % 3;
      end else if (rst_n && mem_req) begin
         if (lat == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mval(mem_addr);
            if (rd_cnt == 0) rd_first = mem_addr;
            rd_cnt++;
         end else lat--;
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FIAL_%s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load_reg(input int idx, input logic [15:0] v);
      @(negedge clk);
      rf_wr_en = 1'b1; rf_wr_idx = 3'(idx); rf_wr_data = v;
      @(negedge clk);
      rf_wr_en = 1'b0;
      mr[idx] = v;
   endtask

   task automatic load_xr(input logic [15:0] v);
      @(negedge clk);
      xr_wr_en = 1'b1; xr_wr_data = v;
      @(negedge clk);
      xr_wr_en = 1'b0;
      mxr = v;
   endtask

   // Issue one instruction and compare against values computed from the requirements
   task automatic run(input logic [3:0] m, input logic [11:0] f, input logic [15:0] pc,
                      input int sel, input string req);
      logic [15:0] r, zf, sf, e_ea, e_op;
      int e_rd, cyc;
      r  = mr[sel];
      zf = {4'b0, f};
      sf = {{4{f[11]}}, f};
      e_rd = 1; e_ea = 16'd0; e_op = 16'd0;
      case (m)
         4'd1: begin e_rd = 0; e_op = zf; end
         4'd2: e_ea = zf;
         4'd3: begin e_ea = mval(zf); e_rd = 2; end
         4'd4: begin e_rd = 0; e_op = r; end
         4'd5: e_ea = r;
         4'd6: begin e_ea = r; mr[sel] = r + 16'd1; end
         4'd7: begin e_ea = r - 16'd1; mr[sel] = e_ea; end
         4'd8: e_ea = pc + sf;
         4'd9: e_ea = mxr + zf;
         4'd10: e_ea = r + zf;
         default: e_rd = 0;
      endcase
      if (e_rd > 0) e_op = mval(e_ea);
      @(negedge clk);
      start = 1'b1; mode = m; addr_field = f; pc_upd = pc; reg_sel = 3'(sel);
      rd_cnt = 0;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 60) begin
         @(negedge clk);
         cyc++;
      end
      chk({req, "_done_seen"}, 16'(done), 16'd1);
      if (e_rd == 0) chk({req, "_latency"}, 16'(cyc), 16'd1);
      chk({req, "_ea"}, ea, e_ea);
      chk({req, "_operand"}, operand, e_op);
      chk({req, "_reads"}, 16'(rd_cnt), 16'(e_rd));
      if (m == 4'd3) chk({req, "_first_read_addr"}, rd_first, zf);
      @(negedge clk);
      chk("R12_done_pulse", 16'(done), 16'd0);
   endtask

   task automatic finish_up;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_up();
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 8; i++) mr[i] = '0;
      repeat (3) @(negedge clk);
      chk("R1_done", 16'(done), 16'd0);
      chk("R1_mem_req", 16'(mem_req), 16'd0);
      chk("R1_ea", ea, 16'd0);
      chk("R1_operand", operand, 16'd0);
      rst_n = 1'b1;
      run(4'd4, 12'd0, 16'd0, 3, "R1_reg_after_reset");

      // Worked example values
      load_reg(1, 16'd400);
      load_xr(16'd100);
      run(4'd2, 12'd500, 16'd202, 1, "R2_direct");
      chk("R2_direct_value", operand, 16'd800);
      run(4'd3, 12'd500, 16'd202, 1, "R3_indirect");
      chk("R3_indirect_value", operand, 16'd300);
      run(4'd8, 12'd500, 16'd202, 1, "R4_relative");
      chk("R4_relative_value", operand, 16'd325);
      run(4'd8, 12'hFCB, 16'd751, 1, "R4_negative_offset");
      chk("R4_branch_target", ea, 16'd698);
      run(4'd9, 12'd500, 16'd202, 1, "R5_indexed");
      chk("R5_indexed_value", operand, 16'd900);
      run(4'd10, 12'd100, 16'd0, 1, "R5_base");
      run(4'd5, 12'd0, 16'd0, 1, "R6_reg_indirect");
      chk("R6_value", operand, 16'd700);
      run(4'd4, 12'd0, 16'd0, 1, "R6_reg_unchanged");
      run(4'd6, 12'd0, 16'd0, 1, "R7_autoinc");
      chk("R7_value", operand, 16'd700);
      run(4'd4, 12'd0, 16'd0, 1, "R7_reg_after");
      chk("R7_reg_401", operand, 16'd401);
      load_reg(1, 16'd400);
      run(4'd7, 12'd0, 16'd0, 1, "R8_autodec");
      chk("R8_value", operand, 16'd450);
      run(4'd4, 12'd0, 16'd0, 1, "R8_reg_after");
      chk("R8_reg_399", operand, 16'd399);
      run(4'd1, 12'd500, 16'd0, 1, "R9_immediate");
      run(4'd1, 12'hFFF, 16'd0, 1, "R9_immediate_zext");
      run(4'd0, 12'd77, 16'd9, 1, "R10_implied");
      run(4'd13, 12'd77, 16'd9, 1, "R10_reserved");
      run(4'd15, 12'd5, 16'd9, 2, "R10_reserved_top");

      // R11 and R13: start and side-port load while busy
      load_reg(2, 16'd55);
      @(negedge clk);
      start = 1'b1; mode = 4'd2; addr_field = 12'd500; reg_sel = 3'd1;
      rd_cnt = 0;
      @(negedge clk);
      mode = 4'd6; reg_sel = 3'd1;
      rf_wr_en = 1'b1; rf_wr_idx = 3'd2; rf_wr_data = 16'd1234;
      @(negedge clk);
      start = 1'b0; rf_wr_en = 1'b0;
      for (int c = 0; c < 60 && !done; c++) @(negedge clk);
      chk("R11_busy_operand", operand, 16'd800);
      chk("R11_busy_reads", 16'(rd_cnt), 16'd1);
      @(negedge clk);
      chk("R11_no_extra_done", 16'(done), 16'd0);
      run(4'd4, 12'd0, 16'd0, 1, "R11_reg_untouched");
      run(4'd4, 12'd0, 16'd0, 2, "R13_load_dropped");
      chk("R13_reg2_value", operand, 16'd55);

      // Constrained random mix
      for (int i = 0; i < 300; i++) begin
         int k;
         k = $urandom % 20;
         if (k == 0) load_reg($urandom % 8, 16'($urandom));
         else if (k == 1) load_xr(16'($urandom));
         else if (k == 2) load_reg($urandom % 8, ($urandom % 2) ? 16'hFFFF : 16'h0000);
         begin
            logic [3:0] m;
            int s;
            m = 4'($urandom % 16);
            s = $urandom % 8;
            case (m)
               4'd2: run(m, 12'($urandom), 16'($urandom), s, "R2_rand");
               4'd3: run(m, 12'($urandom), 16'($urandom), s, "R3_rand");
               4'd8: run(m, 12'($urandom), 16'($urandom), s, "R4_rand");
               4'd9, 4'd10: run(m, 12'($urandom), 16'($urandom), s, "R5_rand");
               4'd5: run(m, 12'($urandom), 16'($urandom), s, "R6_rand");
               4'd6: run(m, 12'($urandom), 16'($urandom), s, "R7_rand");
               4'd7: run(m, 12'($urandom), 16'($urandom), s, "R8_rand");
               4'd1, 4'd4: run(m, 12'($urandom), 16'($urandom), s, "R9_rand");
               default: run(m, 12'($urandom), 16'($urandom), s, "R10_rand");
            endcase
         end
      end
      for (int i = 0; i < 8; i++) run(4'd4, 12'd0, 16'd0, i, "R7_R8_final_regs");
      finish_up();
   end

endmodule